// File: doc/BRIEF.md
# Channel Normalized Address Calculator

This block turns a 48-bit system address into an address relative to one memory channel. It does this by removing a base offset. The offset comes from one of three places: a relocated memory-hole offset, a base offset for the high address range, or the base of the DRAM region that holds the address. Which one applies depends on three things: whether the address fell in the high range, whether hole relocation is on, and whether the address lies at or above 4 GiB. The address and the offset are each trimmed to a fixed granularity before the subtraction. The result is a 64-byte-aligned channel address.

In the same pipeline stage, the block decodes a 3-bit node interleave enable field into a shift amount. Callers use this shift to squeeze node-interleave bits out of the address later on. Every output is registered. A valid strobe marks each request and comes out one cycle later together with its result. Choosing the channel and matching chip selects are done elsewhere.

Top module: `chan_norm_addr`

## Requirements
- R1: In the low range (`hi_range`=0), when `hole_en`=1 and `sys_addr` >= 0x1_0000_0000, the offset is `hole_ofs` shifted left by 16 bits.
- R2: In the low range, in every other case, the offset is `region_base` with bits 26:0 cleared.
- R3: In the high range (`hi_range`=1), the offset is `hole_ofs` shifted left by 16 only when all three hold: `hole_en`=1, `sys_addr` >= 0x1_0000_0000, and bits 31:16 of `sel_base` are all zero. In every other case the offset is `hi_base_ofs`.
- R4: `chan_addr` equals `sys_addr` with bits 5:0 cleared, minus the chosen offset with bits 22:0 cleared. Bits 5:0 of `chan_addr` are therefore always zero.
- R5: The subtraction is 48 bits wide. A borrow wraps modulo 2^48.
- R6: `intlv_shift` is 1 for `intlv_en`=3'b001, 2 for 3'b011, 3 for 3'b111, and 0 for every other value.
- R7: `valid_out` is `valid_in` delayed by exactly one clock. Results appear on the same cycle as their `valid_out`.
- R8: In a cycle where `valid_in`=0, `chan_addr` and `intlv_shift` keep their previous values on the next cycle.
- R9: While `rst_n` is low at a clock edge, `valid_out`, `chan_addr` and `intlv_shift` all go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Request strobe |
| sys_addr | input | 48 | System address |
| hi_range | input | 1 | Address hit the high range |
| sel_base | input | 32 | Controller-select base value |
| hi_base_ofs | input | 48 | High-range base offset |
| hole_en | input | 1 | Memory-hole relocation enabled |
| hole_ofs | input | 16 | Hole offset in 64 KiB units |
| region_base | input | 48 | DRAM region base |
| intlv_en | input | 3 | Node interleave enable field |
| valid_out | output | 1 | Result strobe |
| chan_addr | output | 48 | Channel-relative address |
| intlv_shift | output | 2 | Interleave shift amount |

## Verification
The bench sets addresses at exactly 0x1_0000_0000 and one byte below it. A design whose threshold comparison is off by one picks the wrong offset at one of these two points.

In the high range, it varies each of the three hole conditions in turn. A design that drops the select-base test, or uses the region base in the high range, subtracts the wrong value.

It feeds offsets with bits set below the granularity masks, and a subtraction that underflows. Bad masking shows up as stray low bits in the result. A design with the wrong width or saturating arithmetic does not return the wrapped value.

It also checks that non-mask interleave codes decode to zero, that idle cycles hold the outputs, and that reset clears them.

// File: rtl/cnac_pkg.sv
// Package: shared widths and constants for the channel normalized
// address calculator. Assumes a 48-bit physical address space.
package cnac_pkg;
    localparam int unsigned ADDR_W_DEF     = 48;
    localparam int unsigned SEL_W_DEF      = 32;
    localparam int unsigned HOLE_W_DEF     = 16;
    localparam int unsigned HOLE_SHIFT_DEF = 16;
    localparam int unsigned THRESH_BIT_DEF = 32;
    localparam int unsigned LINE_LSB_DEF   = 6;
    localparam int unsigned OFS_LSB_DEF    = 23;
    localparam int unsigned REGION_LSB_DEF = 27;
    localparam int unsigned IEN_W_DEF      = 3;

    // Which offset source was chosen; used for readability in the selector.
    typedef enum logic [1:0] {
        SRC_REGION = 2'd0,
        SRC_HOLE   = 2'd1,
        SRC_HIBASE = 2'd2
    } ofs_src_e;
endpackage

// File: rtl/cnac_offset_sel.sv
// Module: cnac_offset_sel
// Picks the base offset to be removed from a system address. The choice
// depends on the high-range flag, hole relocation and a threshold bit.
// Purely combinational. Assumes the hole offset is given in 2^HOLE_SHIFT
// byte units. The final granularity mask is applied by the caller.
module cnac_offset_sel
    import cnac_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned SEL_W      = SEL_W_DEF,
    parameter int unsigned HOLE_W     = HOLE_W_DEF,
    parameter int unsigned HOLE_SHIFT = HOLE_SHIFT_DEF,
    parameter int unsigned THRESH_BIT = THRESH_BIT_DEF,
    parameter int unsigned REGION_LSB = REGION_LSB_DEF
) (
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              hi_range,
    input  logic [SEL_W-1:0]  sel_base,
    input  logic [ADDR_W-1:0] hi_base_ofs,
    input  logic              hole_en,
    input  logic [HOLE_W-1:0] hole_ofs,
    input  logic [ADDR_W-1:0] region_base,
    output logic [ADDR_W-1:0] offset
);
    localparam int unsigned      SEL_HALF    = SEL_W / 2;
    localparam logic [ADDR_W-1:0] REGION_MASK = {ADDR_W{1'b1}} << REGION_LSB;

    logic              above_thresh;
    logic              sel_upper_zero;
    logic [ADDR_W-1:0] hole_shifted;
    ofs_src_e          src;

    // Derive the conditions the source choice depends on.
    always_comb begin
        above_thresh   = |sys_addr[ADDR_W-1:THRESH_BIT];
        sel_upper_zero = ~|sel_base[SEL_W-1:SEL_HALF];
        hole_shifted   = ADDR_W'(hole_ofs) << HOLE_SHIFT;
    end

    // Choose the offset source from the range and hole conditions.
    always_comb begin
        if (hi_range) begin
            src = (hole_en && above_thresh && sel_upper_zero) ? SRC_HOLE : SRC_HIBASE;
        end else begin
            src = (hole_en && above_thresh) ? SRC_HOLE : SRC_REGION;
        end
    end

    // Drive the offset value for the chosen source.
    always_comb begin
        unique case (src)
            SRC_HOLE:   offset = hole_shifted;
            SRC_HIBASE: offset = hi_base_ofs;
            default:    offset = region_base & REGION_MASK;
        endcase
    end
endmodule

// File: rtl/cnac_intlv_decode.sv
// Module: cnac_intlv_decode
// Turns a node interleave enable field into a shift amount. A field made of
// k contiguous low ones (k >= 1) gives k. Any other pattern gives 0.
// Purely combinational.
module cnac_intlv_decode #(
    parameter int unsigned IEN_W = 3,
    parameter int unsigned SH_W  = $clog2(IEN_W + 1)
) (
    input  logic [IEN_W-1:0] intlv_en,
    output logic [SH_W-1:0]  shift
);
    logic [IEN_W-1:0] en_plus1;
    logic             is_low_mask;
    logic [SH_W-1:0]  ones;

    // Check for a contiguous low-ones mask and count its bits.
    always_comb begin
        en_plus1    = intlv_en + 1'b1;
        is_low_mask = (intlv_en != '0) && ((intlv_en & en_plus1) == '0);
        ones        = '0;
        for (int i = 0; i < IEN_W; i++) begin
            ones = ones + SH_W'(intlv_en[i]);
        end
        shift = is_low_mask ? ones : '0;
    end
endmodule

// File: rtl/chan_norm_addr.sv
// Module: chan_norm_addr (top)
// One-stage pipelined calculator for channel-relative addresses. It clears
// the line bits of the system address and subtracts the chosen offset at its
// coarse granularity, modulo 2^ADDR_W. It also decodes the interleave shift.
// Outputs load only on valid cycles. Reset is synchronous and active low.
module chan_norm_addr
    import cnac_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned SEL_W      = SEL_W_DEF,
    parameter int unsigned HOLE_W     = HOLE_W_DEF,
    parameter int unsigned HOLE_SHIFT = HOLE_SHIFT_DEF,
    parameter int unsigned THRESH_BIT = THRESH_BIT_DEF,
    parameter int unsigned LINE_LSB   = LINE_LSB_DEF,
    parameter int unsigned OFS_LSB    = OFS_LSB_DEF,
    parameter int unsigned REGION_LSB = REGION_LSB_DEF,
    parameter int unsigned IEN_W      = IEN_W_DEF,
    localparam int unsigned SH_W      = $clog2(IEN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [ADDR_W-1:0] sys_addr,
    input  logic              hi_range,
    input  logic [SEL_W-1:0]  sel_base,
    input  logic [ADDR_W-1:0] hi_base_ofs,
    input  logic              hole_en,
    input  logic [HOLE_W-1:0] hole_ofs,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [IEN_W-1:0]  intlv_en,
    output logic              valid_out,
    output logic [ADDR_W-1:0] chan_addr,
    output logic [SH_W-1:0]   intlv_shift
);
    localparam logic [ADDR_W-1:0] LINE_MASK = {ADDR_W{1'b1}} << LINE_LSB;
    localparam logic [ADDR_W-1:0] OFS_MASK  = {ADDR_W{1'b1}} << OFS_LSB;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] diff;
    logic [SH_W-1:0]   shift_d;

    cnac_offset_sel #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .HOLE_W    (HOLE_W),
        .HOLE_SHIFT(HOLE_SHIFT),
        .THRESH_BIT(THRESH_BIT),
        .REGION_LSB(REGION_LSB)
    ) ofs_sel_i (
        .sys_addr   (sys_addr),
        .hi_range   (hi_range),
        .sel_base   (sel_base),
        .hi_base_ofs(hi_base_ofs),
        .hole_en    (hole_en),
        .hole_ofs   (hole_ofs),
        .region_base(region_base),
        .offset     (offset)
    );

    cnac_intlv_decode #(
        .IEN_W(IEN_W),
        .SH_W (SH_W)
    ) ilv_dec_i (
        .intlv_en(intlv_en),
        .shift   (shift_d)
    );

    // Trim both operands to their granularity and subtract, wrapping on borrow.
    always_comb begin
        diff = (sys_addr & LINE_MASK) - (offset & OFS_MASK);
    end

    // Register the strobe every cycle, and the results on valid cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out   <= 1'b0;
            chan_addr   <= '0;
            intlv_shift <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                chan_addr   <= diff;
                intlv_shift <= shift_d;
            end
        end
    end

    // R7
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R7
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(chan_addr) && $stable(intlv_shift)));

    // R4
    line_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (chan_addr[LINE_LSB-1:0] == '0));

    // R6
    even_code_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !intlv_en[0]) |=> (intlv_shift == '0));
endmodule

// File: tb/chan_norm_addr_tb_top.sv
// Bench for chan_norm_addr: walks a vector table, then runs directed tests.
module chan_norm_addr_tb_top;
    typedef struct packed {
        logic        hi;
        logic [31:0] selb;
        logic [47:0] hib;
        logic        he;
        logic [15:0] hofs;
        logic [47:0] rb;
        logic [47:0] addr;
        logic [2:0]  ien;
        logic [47:0] exp_addr;
        logic [1:0]  exp_sh;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        // R2 region base offset, low range, hole off
        '{1'b0, 32'h0, 48'h0, 1'b0, 16'h0, 48'h0000_1800_0000, 48'h0000_2345_6789, 3'b001, 48'h0000_0B45_6780, 2'd1, 8'd2},
        // R2 region base low bits dropped
        '{1'b0, 32'h0, 48'h0, 1'b0, 16'h0, 48'h0000_0FFF_FFFF, 48'h0000_1000_0040, 3'b011, 48'h0000_0800_0040, 2'd2, 8'd2},
        // R1 hole offset above 4 GiB
        '{1'b0, 32'h0, 48'h0, 1'b1, 16'h0080, 48'h0000_4000_0000, 48'h0001_2000_0000, 3'b111, 48'h0001_1F80_0000, 2'd3, 8'd1},
        // R1 exactly at threshold
        '{1'b0, 32'h0, 48'h0, 1'b1, 16'h1000, 48'h0, 48'h0001_0000_0000, 3'b000, 48'h0000_F000_0000, 2'd0, 8'd1},
        // R2 one byte below threshold, hole on
        '{1'b0, 32'h0, 48'h0, 1'b1, 16'h1000, 48'h0000_0800_0000, 48'h0000_FFFF_FFFF, 3'b010, 48'h0000_F7FF_FFC0, 2'd0, 8'd2},
        // R3 high range, hole used
        '{1'b1, 32'h0000_1234, 48'h0000_8000_0000, 1'b1, 16'h2000, 48'h0, 48'h0002_0000_0000, 3'b100, 48'h0001_E000_0000, 2'd0, 8'd3},
        // R3 high range, select base upper bits set
        '{1'b1, 32'h0001_0000, 48'h0000_8000_0000, 1'b1, 16'h2000, 48'h0, 48'h0002_0000_0000, 3'b101, 48'h0001_8000_0000, 2'd0, 8'd3},
        // R3 high range, hole disabled
        '{1'b1, 32'h0, 48'h0000_8000_0000, 1'b0, 16'h2000, 48'h0, 48'h0002_0000_0000, 3'b110, 48'h0001_8000_0000, 2'd0, 8'd3},
        // R3 high range below 4 GiB, high base low bits masked (R4)
        '{1'b1, 32'h0, 48'h0000_407F_FFFF, 1'b1, 16'h2000, 48'h0, 48'h0000_C000_0000, 3'b001, 48'h0000_8000_0000, 2'd1, 8'd3},
        // R5 borrow wraps
        '{1'b0, 32'h0, 48'h0, 1'b0, 16'h0, 48'h0000_1000_0000, 48'h0000_0000_0100, 3'b011, 48'hFFFF_F000_0100, 2'd2, 8'd5},
        // R4 line bits cleared, zero offset
        '{1'b0, 32'h0, 48'h0, 1'b0, 16'h0, 48'h0, 48'hFFFF_FFFF_FFFF, 3'b111, 48'hFFFF_FFFF_FFC0, 2'd3, 8'd4},
        // R1 hole offset low bits below mask vanish
        '{1'b0, 32'h0, 48'h0, 1'b1, 16'h00FF, 48'h0, 48'h0001_0000_0000, 3'b000, 48'h0000_FF80_0000, 2'd0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_in;
    logic [47:0] sys_addr;
    logic        hi_range;
    logic [31:0] sel_base;
    logic [47:0] hi_base_ofs;
    logic        hole_en;
    logic [15:0] hole_ofs;
    logic [47:0] region_base;
    logic [2:0]  intlv_en;
    logic        valid_out;
    logic [47:0] chan_addr;
    logic [1:0]  intlv_shift;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    chan_norm_addr dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .sys_addr(sys_addr),
        .hi_range(hi_range), .sel_base(sel_base), .hi_base_ofs(hi_base_ofs),
        .hole_en(hole_en), .hole_ofs(hole_ofs), .region_base(region_base),
        .intlv_en(intlv_en), .valid_out(valid_out), .chan_addr(chan_addr),
        .intlv_shift(intlv_shift)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%012h expected=0x%012h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        hi_range = v.hi; sel_base = v.selb; hi_base_ofs = v.hib; hole_en = v.he;
        hole_ofs = v.hofs; region_base = v.rb; sys_addr = v.addr; intlv_en = v.ien;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; valid_in = 1'b1;
        apply(VT[0]);
        repeat (3) @(negedge clk);
        // R9 reset state, even with valid_in high
        check("R9 valid_out", 48'(valid_out), 48'h0);
        check("R9 chan_addr", chan_addr, 48'h0);
        check("R9 intlv_shift", 48'(intlv_shift), 48'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            valid_in = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d addr", VT[i].req, i), chan_addr, VT[i].exp_addr);
            check($sformatf("R6 vec%0d shift", i), 48'(intlv_shift), 48'(VT[i].exp_sh));
            check("R7 valid_out high", 48'(valid_out), 48'h1);
        end

        // R8 idle cycle: change inputs, outputs must hold the last result
        valid_in = 1'b0;
        apply(VT[0]);
        @(negedge clk);
        check("R7 valid_out low", 48'(valid_out), 48'h0);
        check("R8 chan_addr hold", chan_addr, VT[NV-1].exp_addr);
        check("R8 intlv_shift hold", 48'(intlv_shift), 48'(VT[NV-1].exp_sh));

        // R7 strobe returns one cycle after valid_in
        valid_in = 1'b1;
        @(negedge clk);
        check("R7 valid_out again", 48'(valid_out), 48'h1);
        check("R2 vec0 after idle", chan_addr, VT[0].exp_addr);
        check("R6 vec0 after idle", 48'(intlv_shift), 48'd1);

        // R9 reset in mid-run clears loaded outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid valid_out", 48'(valid_out), 48'h0);
        check("R9 mid chan_addr", chan_addr, 48'h0);
        check("R9 mid intlv_shift", 48'(intlv_shift), 48'h0);
        rst_n = 1'b1;
        valid_in = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule